// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each cycle it can accept one operation together with the accumulator value, one operand byte, the current flag byte and a 16-bit register pair. One cycle later it presents the new data byte, the new flag byte and the updated register pair. The surrounding core writes the result back to the accumulator or to the register it came from. Instruction fetch, decode, addressing and decimal adjust belong to the surrounding core.

The flag byte holds six meaningful bits: sign, zero, half-carry, parity/overflow, subtract and carry. Each class of operation updates its own subset of these bits. Arithmetic operations write signed overflow into the parity/overflow bit. Bitwise operations write even parity into that same bit. Subtraction reports a borrow in the carry bit. The two spare bits of the flag byte pass through unchanged. A 16-bit step path counts the register pair up or down and never touches the flags.

Top module: `acc_flag_alu`

## Requirements
- R1: While rstN is low, resValid, result, flagsOut and pairOut are all zero.
- R2: Opcode 0 (add) gives result = accIn + operandIn mod 256. The flags are set as follows: C is the carry out of bit 7, H is the carry out of bit 3, PV is signed overflow, N = 0, S = bit 7 of the result, and Z = 1 when the result is zero.
- R3: Opcode 1 (subtract) gives result = accIn - operandIn mod 256. C = 1 on a borrow, H = 1 on a borrow from bit 4, PV is signed overflow, N = 1, and S and Z follow the result.
- R4: Opcodes 2 (increment) and 3 (decrement) give operandIn + 1 and operandIn - 1. C keeps its input value. PV = 1 exactly for 7Fh incremented or 80h decremented. H is the nibble carry or borrow. N is 0 for increment and 1 for decrement. S and Z follow the result.
- R5: Opcode 5 (negate) gives 0 - accIn. C = 1 when accIn is nonzero, PV = 1 only for accIn = 80h, H = 1 when the low nibble of accIn is nonzero, N = 1, and S and Z follow the result.
- R6: Opcode 4 (complement) gives the bitwise inverse of accIn, sets H and N to 1, and keeps S, Z, PV and C.
- R7: Opcodes 6, 7 and 8 give accIn AND, OR and XOR operandIn. PV = 1 when the result has an even number of one bits. C = 0 and N = 0. H = 1 for AND and 0 for OR and XOR. S and Z follow the result.
- R8: Opcodes 9 and 10 give pairOut = pairIn + 1 and pairIn - 1, wrapping mod 65536. They also give result = accIn and flagsOut = flagsIn. Every other opcode gives pairOut = pairIn.
- R9: The flag byte layout is: bit 7 S, bit 6 Z, bit 4 H, bit 2 PV, bit 1 N, bit 0 C. Bits 5 and 3 are copied from flagsIn for every opcode.
- R10: Outputs update on the clock edge that samples opValid high, and resValid is that opValid delayed by one cycle. While opValid is low, result, flagsOut and pairOut hold their values.
- R11: Opcodes 11 to 15 give result = accIn, flagsOut = flagsIn and pairOut = pairIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | The operation on the inputs is to be executed |
| opCode | input | 4 | Operation selector |
| accIn | input | DATA_W | Accumulator value |
| operandIn | input | DATA_W | Second operand, or the register being stepped |
| flagsIn | input | 8 | Current flag byte |
| pairIn | input | 2*DATA_W | Register pair for 16-bit stepping |
| resValid | output | 1 | Outputs carry a new operation's outcome |
| result | output | DATA_W | New data byte |
| flagsOut | output | 8 | New flag byte |
| pairOut | output | 2*DATA_W | Stepped register pair |

## Verification
The bench builds the block with DATA_W = 8, so the pair path is 16 bits wide. At that width, random bytes cross the bit 3 and bit 7 carry boundaries, the 7Fh/80h overflow points and zero results often. Directed vectors pin the named sums and differences, the 80h negate case and the wrap of the pair at FFFFh and 0000h. Idle cycles are mixed in to test that outputs hold, and undefined opcodes are driven to test that they pass values through.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_CPL  = 4'd4,
    OP_NEG  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_INCW = 4'd9,
    OP_DECW = 4'd10
  } aluOp_e;

  // flag byte bit positions, decoded by the branch logic of the core
  localparam int FLAG_C  = 0;
  localparam int FLAG_N  = 1;
  localparam int FLAG_PV = 2;
  localparam int FLAG_H  = 4;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_S  = 7;

  typedef enum logic [1:0] {X_ACC, X_OPND, X_ZERO} xSel_e;
  typedef enum logic [1:0] {Y_OPND, Y_ONE, Y_ACC, Y_NONE} ySel_e;
  typedef enum logic [1:0] {RES_ADDER, RES_LOGIC, RES_CPL, RES_ACC} resSel_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} logicSel_e;
  typedef enum logic [1:0] {PAIR_HOLD, PAIR_UP, PAIR_DOWN} pairStep_e;

  typedef struct packed {
    logic      load;
    xSel_e     xSel;
    ySel_e     ySel;
    logic      yInv;
    logic      carryIn;
    logic      borrowSense;
    resSel_e   resSel;
    logicSel_e logicSel;
    logic      updMain;
    logic      updCarry;
    logic      updCpl;
    logic      pvParity;
    logic      subFlag;
    logic      halfLogic;
    pairStep_e pairStep;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic        opValid,
  input  logic [3:0]  opCode,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes             = '0;
    strobes.load        = opValid;
    strobes.xSel        = X_ACC;
    strobes.ySel        = Y_OPND;
    strobes.resSel      = RES_ACC;
    strobes.logicSel    = LG_AND;
    strobes.pairStep    = PAIR_HOLD;
    case (opCode)
      OP_ADD: begin
        strobes.resSel   = RES_ADDER;
        strobes.updMain  = 1'b1;
        strobes.updCarry = 1'b1;
      end
      OP_SUB: begin
        strobes.yInv        = 1'b1;
        strobes.carryIn     = 1'b1;
        strobes.borrowSense = 1'b1;
        strobes.resSel      = RES_ADDER;
        strobes.updMain     = 1'b1;
        strobes.updCarry    = 1'b1;
        strobes.subFlag     = 1'b1;
      end
      OP_INC: begin
        strobes.xSel    = X_OPND;
        strobes.ySel    = Y_NONE;
        strobes.carryIn = 1'b1;
        strobes.resSel  = RES_ADDER;
        strobes.updMain = 1'b1;
      end
      OP_DEC: begin
        strobes.xSel        = X_OPND;
        strobes.ySel        = Y_ONE;
        strobes.yInv        = 1'b1;
        strobes.carryIn     = 1'b1;
        strobes.borrowSense = 1'b1;
        strobes.resSel      = RES_ADDER;
        strobes.updMain     = 1'b1;
        strobes.subFlag     = 1'b1;
      end
      OP_CPL: begin
        strobes.resSel = RES_CPL;
        strobes.updCpl = 1'b1;
      end
      OP_NEG: begin
        strobes.xSel        = X_ZERO;
        strobes.ySel        = Y_ACC;
        strobes.yInv        = 1'b1;
        strobes.carryIn     = 1'b1;
        strobes.borrowSense = 1'b1;
        strobes.resSel      = RES_ADDER;
        strobes.updMain     = 1'b1;
        strobes.updCarry    = 1'b1;
        strobes.subFlag     = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobes.resSel    = RES_LOGIC;
        strobes.logicSel  = (opCode == OP_AND) ? LG_AND :
                            (opCode == OP_OR)  ? LG_OR  : LG_XOR;
        strobes.halfLogic = (opCode == OP_AND);
        strobes.pvParity  = 1'b1;
        strobes.updMain   = 1'b1;
        strobes.updCarry  = 1'b1;
      end
      OP_INCW: strobes.pairStep = PAIR_UP;
      OP_DECW: strobes.pairStep = PAIR_DOWN;
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PAIR_W = 2 * DATA_W,
  localparam int MSB    = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [7:0]        flagsIn,
  input  logic [PAIR_W-1:0] pairIn,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flagsOut,
  output logic [PAIR_W-1:0] pairOut
);

  logic [DATA_W-1:0] xVal, yRaw, yEff, logicVal, resNext;
  logic [DATA_W:0]   sumFull;
  logic [4:0]        nibSum;
  logic              ovf, parityEven;
  logic [7:0]        flagsNext;
  logic [PAIR_W-1:0] pairNext;

  always_comb begin
    case (strobes.xSel)
      X_ACC:   xVal = accIn;
      X_OPND:  xVal = operandIn;
      default: xVal = '0;
    endcase
    case (strobes.ySel)
      Y_OPND:  yRaw = operandIn;
      Y_ONE:   yRaw = DATA_W'(1);
      Y_ACC:   yRaw = accIn;
      default: yRaw = '0;
    endcase
    yEff    = strobes.yInv ? ~yRaw : yRaw;
    sumFull = {1'b0, xVal} + {1'b0, yEff} + {{DATA_W{1'b0}}, strobes.carryIn};
    nibSum  = {1'b0, xVal[3:0]} + {1'b0, yEff[3:0]} + {4'b0, strobes.carryIn};
    ovf     = (xVal[MSB] == yEff[MSB]) && (sumFull[MSB] != xVal[MSB]);
  end

  always_comb begin
    case (strobes.logicSel)
      LG_AND:  logicVal = accIn & operandIn;
      LG_OR:   logicVal = accIn | operandIn;
      default: logicVal = accIn ^ operandIn;
    endcase
    case (strobes.resSel)
      RES_ADDER: resNext = sumFull[DATA_W-1:0];
      RES_LOGIC: resNext = logicVal;
      RES_CPL:   resNext = ~accIn;
      default:   resNext = accIn;
    endcase
    parityEven = ~^resNext;
  end

  always_comb begin
    flagsNext = flagsIn;
    if (strobes.updMain) begin
      flagsNext[FLAG_S]  = resNext[MSB];
      flagsNext[FLAG_Z]  = (resNext == '0);
      flagsNext[FLAG_PV] = strobes.pvParity ? parityEven : ovf;
      flagsNext[FLAG_H]  = (strobes.resSel == RES_LOGIC) ? strobes.halfLogic
                                                         : (nibSum[4] ^ strobes.borrowSense);
      flagsNext[FLAG_N]  = strobes.subFlag;
    end
    if (strobes.updCarry)
      flagsNext[FLAG_C] = (strobes.resSel == RES_LOGIC) ? 1'b0
                                                        : (sumFull[DATA_W] ^ strobes.borrowSense);
    if (strobes.updCpl) begin
      flagsNext[FLAG_H] = 1'b1;
      flagsNext[FLAG_N] = 1'b1;
    end
  end

  always_comb begin
    case (strobes.pairStep)
      PAIR_UP:   pairNext = pairIn + PAIR_W'(1);
      PAIR_DOWN: pairNext = pairIn - PAIR_W'(1);
      default:   pairNext = pairIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      result   <= '0;
      flagsOut <= '0;
      pairOut  <= '0;
    end else begin
      resValid <= strobes.load;
      if (strobes.load) begin
        result   <= resNext;
        flagsOut <= flagsNext;
        pairOut  <= pairNext;
      end
    end
  end

endmodule

// File: rtl/acc_flag_alu.sv
module acc_flag_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PAIR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [7:0]        flagsIn,
  input  logic [PAIR_W-1:0] pairIn,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flagsOut,
  output logic [PAIR_W-1:0] pairOut
);

  aluStrobes_t strobes;

  alu_ctrl ctrlInst (
    .opValid (opValid),
    .opCode  (opCode),
    .strobes (strobes)
  );

  alu_dpath #(.DATA_W(DATA_W)) dpathInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .accIn     (accIn),
    .operandIn (operandIn),
    .flagsIn   (flagsIn),
    .pairIn    (pairIn),
    .resValid  (resValid),
    .result    (result),
    .flagsOut  (flagsOut),
    .pairOut   (pairOut)
  );

endmodule

// File: rtl/alu_chk.sv
module alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PAIR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] operandIn,
  input logic [7:0]        flagsIn,
  input logic [PAIR_W-1:0] pairIn,
  input logic              resValid,
  input logic [DATA_W-1:0] result,
  input logic [7:0]        flagsOut,
  input logic [PAIR_W-1:0] pairOut
);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid && $stable(result) && $stable(flagsOut) && $stable(pairOut));

  // R9
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> flagsOut[5] == $past(flagsIn[5]) && flagsOut[3] == $past(flagsIn[3]));

  // R4
  step_carry_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opCode == OP_INC || opCode == OP_DEC)
      |=> flagsOut[FLAG_C] == $past(flagsIn[FLAG_C]));

  // R4
  inc_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OP_INC |=> result == DATA_W'($past(operandIn) + 1'b1));

  // R6
  cpl_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OP_CPL
      |=> result == ~$past(accIn) && flagsOut[FLAG_H] && flagsOut[FLAG_N]);

  // R7
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR)
      |=> !flagsOut[FLAG_C] && !flagsOut[FLAG_N]);

  // R8
  pair_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OP_INCW
      |=> pairOut == PAIR_W'($past(pairIn) + 1'b1) && flagsOut == $past(flagsIn));

endmodule

bind acc_flag_alu alu_chk #(.DATA_W(DATA_W)) chkInst (.*);

// File: tb/acc_flag_alu_test.sv
`timescale 1ns/1ps
module acc_flag_alu_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [3:0]  opCode;
  logic [7:0]  accIn, operandIn, flagsIn;
  logic [15:0] pairIn;
  logic        resValid;
  logic [7:0]  result, flagsOut;
  logic [15:0] pairOut;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  logic        expValid;
  logic [7:0]  expRes, expFlags;
  logic [15:0] expPair;
  string       expTag;

  always #4 clk = ~clk;

  acc_flag_alu uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .operandIn(operandIn), .flagsIn(flagsIn), .pairIn(pairIn),
    .resValid(resValid), .result(result), .flagsOut(flagsOut), .pairOut(pairOut)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R10", "resValid", 32'(resValid), 32'(expValid));
    check(expTag, "result", 32'(result), 32'(expRes));
    check(expTag, "flags", 32'(flagsOut & 8'hD7), 32'(expFlags & 8'hD7));
    check("R9", "spare flag bits", 32'(flagsOut & 8'h28), 32'(expFlags & 8'h28));
    check(expTag, "pair", 32'(pairOut), 32'(expPair));
  endtask

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic bit evenOnes(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  // behavioural reference for one operation
  task automatic model(int op, int a, int b, logic [7:0] f, logic [15:0] p);
    int  r = a, s;
    bit  h = 0, pv = 0, n = 0, c = f[0];
    bit  touchMain = 1;
    logic [7:0] nf = f;
    expPair = p;
    case (op)
      0: begin s = a + b; r = s % 256; c = s > 255; h = (a % 16 + b % 16) > 15;
               s = sx(a) + sx(b); pv = (s > 127) || (s < -128); n = 0; expTag = "R2"; end
      1: begin s = a - b; r = (s + 256) % 256; c = s < 0; h = (a % 16 - b % 16) < 0;
               s = sx(a) - sx(b); pv = (s > 127) || (s < -128); n = 1; expTag = "R3"; end
      2: begin r = (b + 1) % 256; h = (b % 16) == 15; pv = b == 127; n = 0; expTag = "R4"; end
      3: begin r = (b + 255) % 256; h = (b % 16) == 0; pv = b == 128; n = 1; expTag = "R4"; end
      4: begin r = 255 - a; touchMain = 0; nf[4] = 1; nf[1] = 1; expTag = "R6"; end
      5: begin r = (256 - a) % 256; c = a != 0; h = (a % 16) != 0; pv = a == 128; n = 1;
               expTag = "R5"; end
      6, 7, 8: begin
               r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (a ^ b);
               pv = evenOnes(r); c = 0; n = 0; h = (op == 6); expTag = "R7"; end
      9:  begin touchMain = 0; expPair = p + 16'd1; expTag = "R8"; end
      10: begin touchMain = 0; expPair = p - 16'd1; expTag = "R8"; end
      default: begin touchMain = 0; expTag = "R11"; end
    endcase
    if (touchMain) begin
      nf[7] = r[7]; nf[6] = (r == 0); nf[4] = h; nf[2] = pv; nf[1] = n; nf[0] = c;
    end
    expRes   = 8'(r);
    expFlags = nf;
  endtask

  task automatic applyOp(bit v, int op, int a, int b, logic [7:0] f, logic [15:0] p);
    @(negedge clk);
    compareAll();
    opValid = v; opCode = 4'(op); accIn = 8'(a); operandIn = 8'(b);
    flagsIn = f; pairIn = p;
    if (v) model(op, a, b, f, p);
    else expTag = "R10";
    expValid = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; opValid = 0; opCode = 0; accIn = 0; operandIn = 0;
    flagsIn = 0; pairIn = 0;
    expValid = 0; expRes = 0; expFlags = 0; expPair = 0; expTag = "R1";
    repeat (3) @(negedge clk);
    // R1 reset state
    compareAll();
    rstN = 1'b1;
    // R2 named sums
    applyOp(1, 0, 8'h29, 8'h76, 8'h00, 16'h0000);
    applyOp(1, 0, 8'h75, 8'hA2, 8'hFF, 16'h1234);
    // R3 named difference and borrow
    applyOp(1, 1, 8'hF2, 8'h68, 8'h00, 16'h0000);
    applyOp(1, 1, 8'h10, 8'h20, 8'h00, 16'h0000);
    // R4 overflow points, carry kept both ways
    applyOp(1, 2, 8'h00, 8'h7F, 8'h01, 16'h0000);
    applyOp(1, 3, 8'h00, 8'h80, 8'h00, 16'h0000);
    applyOp(1, 3, 8'h00, 8'h00, 8'h01, 16'h0000);
    // R5 negate corners
    applyOp(1, 5, 8'h80, 8'h00, 8'h00, 16'h0000);
    applyOp(1, 5, 8'h00, 8'h00, 8'hFF, 16'h0000);
    // R6 complement keeps S Z PV C
    applyOp(1, 4, 8'h8A, 8'h00, 8'hC5, 16'h0000);
    // R7 parity
    applyOp(1, 6, 8'hF0, 8'h3C, 8'h01, 16'h0000);
    applyOp(1, 8, 8'h01, 8'h00, 8'h01, 16'h0000);
    // R8 pair wrap
    applyOp(1, 9, 8'h55, 8'h00, 8'hA5, 16'hFFFF);
    applyOp(1, 10, 8'h55, 8'h00, 8'h5A, 16'h0000);
    // R11 undefined opcode
    applyOp(1, 13, 8'h3C, 8'h99, 8'h6B, 16'hBEEF);
    // R10 idle hold
    applyOp(0, 0, 8'hFF, 8'hFF, 8'hFF, 16'hFFFF);
    applyOp(0, 1, 8'h00, 8'h01, 8'h00, 16'h0001);
    for (int i = 0; i < 4000; i++)
      applyOp(($urandom % 5) != 0, $urandom % 16, $urandom % 256, $urandom % 256,
              8'($urandom), 16'($urandom));
    @(negedge clk);
    compareAll();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule